// File: doc/BRIEF.md
# Flash Busy Status and Erase Timer

This block produces the status word a host polls while a parallel NOR flash runs its embedded program or erase algorithm. The command decoder, which lies outside this block, raises one of three single-cycle start pulses: program, chip erase or sector erase. With the program pulse it also supplies the data byte being written. The host then reads status through a read strobe. Bit 7 (data poll) reports completion. Bit 6 (toggle) inverts after every read, so two back-to-back reads differ while the device is still working.

A program completes at once, and only the poll bit is updated. An erase loads a down-counter that stands in for the erase time. The busy flag is high while that counter is non-zero. When the counter runs out, the poll bit is inverted and `erase_done_o` pulses for one cycle. The command decoder uses that pulse to leave its erase mode. The two durations are parameters. By default the chip erase is ten times the sector erase, and both are kept short for simulation.

Top module: `flash_busy_status`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `status_o` is 0x00, `busy_o` is 0 and `erase_done_o` is 0.
- R2: A program pulse sets `status_o[7]` to the inverse of `prog_data_i[7]` from the next cycle on. It starts no timer, so `busy_o` stays 0 and `erase_done_o` does not pulse.
- R3: A chip or sector erase pulse clears `status_o[7]` to 0 and raises `busy_o` from the next cycle on.
- R4: `status_o` shows the status before the read takes effect. Each cycle with `status_rd_i` high inverts `status_o[6]` in the following cycle. Cycles without a read leave bit 6 unchanged.
- R5: After a sector erase pulse, `busy_o` is high for exactly SECTOR_ERASE_CYCLES cycles.
- R6: After a chip erase pulse, `busy_o` is high for exactly CHIP_ERASE_CYCLES cycles. The default is 10 times the sector duration.
- R7: In the first cycle in which `busy_o` is low after an erase, `erase_done_o` is high for that one cycle and `status_o[7]` has been inverted.
- R8: An erase pulse that arrives while busy reloads the counter to the full new duration. The interrupted erase produces no `erase_done_o`.
- R9: When pulses coincide, a chip erase takes precedence over a sector erase for the duration, and any erase takes precedence over a program for `status_o[7]`.
- R10: Status bits 5 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_start_i | input | 1 | Program start pulse |
| prog_data_i | input | 8 | Data byte being programmed |
| chip_erase_i | input | 1 | Chip erase start pulse |
| sector_erase_i | input | 1 | Sector erase start pulse |
| status_rd_i | input | 1 | Status read strobe, one per read |
| status_o | output | 8 | Status word |
| busy_o | output | 1 | Erase timer running |
| erase_done_o | output | 1 | One-cycle erase completion pulse |

## Verification
The assertions assume that start pulses are one cycle wide. They also assume that no program pulse lands in the cycle in which an erase expires, because in that cycle the program would own the poll bit. The bench drives every pulse for a single cycle, on the falling edge. It lets each erase run to completion before it issues a program. Reads are issued only between other stimuli, so only the toggle bit is ever affected by them.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam int POLL_BIT = 7;
  localparam int TGL_BIT  = 6;

  typedef logic [7:0] stat_t;

  typedef enum logic [1:0] {
    START_NONE   = 2'd0,
    START_PROG   = 2'd1,
    START_SECTOR = 2'd2,
    START_CHIP   = 2'd3
  } start_e;
endpackage

// File: rtl/flash_start_dec.sv
module flash_start_dec
  import flash_stat_pkg::*;
(
  input  logic   prog_i,
  input  logic   chip_i,
  input  logic   sector_i,
  output start_e kind_o
);
  // chip > sector > program
  always_comb begin
    if (chip_i)        kind_o = START_CHIP;
    else if (sector_i) kind_o = START_SECTOR;
    else if (prog_i)   kind_o = START_PROG;
    else               kind_o = START_NONE;
  end
endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          busy_o,
  output logic          expire_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;
  logic          done_q;

  // a reload in the last cycle cancels the expiry
  assign expire_o = (cnt_q == CW'(1)) && !load_i;
  assign busy_o   = (cnt_q != '0);
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= expire_o;
      if (load_i)      cnt_q <= load_val_i;
      else if (busy_o) cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/flash_status_word.sv
module flash_status_word
  import flash_stat_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  start_e kind_i,
  input  logic   prog_bit_i,
  input  logic   expire_i,
  input  logic   rd_i,
  output stat_t  stat_o
);
  stat_t stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    unique case (kind_i)
      START_CHIP, START_SECTOR: stat_d[POLL_BIT] = 1'b0;
      START_PROG:               stat_d[POLL_BIT] = ~prog_bit_i;
      default: if (expire_i)    stat_d[POLL_BIT] = ~stat_q[POLL_BIT];
    endcase
    if (rd_i) stat_d[TGL_BIT] = ~stat_q[TGL_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
  import flash_stat_pkg::*;
#(
  parameter int SECTOR_ERASE_CYCLES = 20,
  parameter int CHIP_ERASE_CYCLES   = 10 * SECTOR_ERASE_CYCLES
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       prog_start_i,
  input  logic [7:0] prog_data_i,
  input  logic       chip_erase_i,
  input  logic       sector_erase_i,
  input  logic       status_rd_i,
  output logic [7:0] status_o,
  output logic       busy_o,
  output logic       erase_done_o
);
  localparam int MAXC = (CHIP_ERASE_CYCLES > SECTOR_ERASE_CYCLES) ?
                        CHIP_ERASE_CYCLES : SECTOR_ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  start_e        kind;
  logic          load;
  logic [CW-1:0] load_val;
  logic          expire;

  flash_start_dec u_dec (
    .prog_i   (prog_start_i),
    .chip_i   (chip_erase_i),
    .sector_i (sector_erase_i),
    .kind_o   (kind)
  );

  assign load     = (kind == START_CHIP) || (kind == START_SECTOR);
  assign load_val = (kind == START_CHIP) ? CW'(CHIP_ERASE_CYCLES) : CW'(SECTOR_ERASE_CYCLES);

  flash_erase_timer #(.CW(CW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .busy_o     (busy_o),
    .expire_o   (expire),
    .done_o     (erase_done_o)
  );

  flash_status_word u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (kind),
    .prog_bit_i (prog_data_i[7]),
    .expire_i   (expire),
    .rd_i       (status_rd_i),
    .stat_o     (status_o)
  );
endmodule

// File: rtl/flash_busy_status_chk.sv
module flash_busy_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       prog_start_i,
  input logic [7:0] prog_data_i,
  input logic       chip_erase_i,
  input logic       sector_erase_i,
  input logic       status_rd_i,
  input logic [7:0] status_o,
  input logic       busy_o,
  input logic       erase_done_o
);
  logic erase_start;
  assign erase_start = chip_erase_i || sector_erase_i;

  // R2
  prog_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_start_i && !erase_start) |=> (status_o[7] == !$past(prog_data_i[7])));

  // R3
  erase_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start |=> (busy_o && !status_o[7]));

  // R4
  rd_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i |=> (status_o[6] != $past(status_o[6])));

  // R4
  no_rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_rd_i |=> $stable(status_o[6]));

  // R7
  done_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> erase_done_o);

  // R7
  done_poll_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_done_o && !$past(prog_start_i)) |-> (status_o[7] != $past(status_o[7])));

  // R8
  reload_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_start && busy_o) |=> !erase_done_o);

  // R10
  low_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5:0] == 6'd0);
endmodule

bind flash_busy_status flash_busy_status_chk u_chk (.*);

// File: tb/tb_flash_busy_status.sv
module tb_flash_busy_status;
  localparam int SEC  = 20;
  localparam int CHIP = 200;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       prog_start_i = 1'b0;
  logic [7:0] prog_data_i = 8'h00;
  logic       chip_erase_i = 1'b0;
  logic       sector_erase_i = 1'b0;
  logic       status_rd_i = 1'b0;
  logic [7:0] status_o;
  logic       busy_o;
  logic       erase_done_o;

  int n_chk = 0;
  int n_bad = 0;
  logic exp7 = 1'b0;
  logic exp6 = 1'b0;

  always #2 clk = ~clk;

  flash_busy_status #(.SECTOR_ERASE_CYCLES(SEC), .CHIP_ERASE_CYCLES(CHIP)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .prog_start_i(prog_start_i), .prog_data_i(prog_data_i),
    .chip_erase_i(chip_erase_i), .sector_erase_i(sector_erase_i), .status_rd_i(status_rd_i),
    .status_o(status_o), .busy_o(busy_o), .erase_done_o(erase_done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one-cycle pulse, driven and released on falling edges
  task automatic pulse(input logic p, input logic [7:0] d, input logic c, input logic s, input logic r);
    prog_start_i = p; prog_data_i = d; chip_erase_i = c; sector_erase_i = s; status_rd_i = r;
    @(negedge clk);
    prog_start_i = 0; chip_erase_i = 0; sector_erase_i = 0; status_rd_i = 0;
  endtask

  // count busy cycles from the first sample after the start edge
  task automatic run_erase(input string req, input int exp_len);
    int n = 0;
    while (busy_o && n < 1000) begin
      chk("R7", erase_done_o, 0);
      n++;
      @(negedge clk);
    end
    exp7 = ~exp7;
    chk(req, n, exp_len);
    chk("R7", erase_done_o, 1);
    chk("R7", status_o[7], exp7);
    @(negedge clk);
    chk("R7", erase_done_o, 0);
  endtask

  task automatic t_reset;
    chk("R1", status_o, 8'h00);
    chk("R1", busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", status_o, 8'h00);
    chk("R1", busy_o, 0);
    chk("R1", erase_done_o, 0);
  endtask

  task automatic t_program;
    pulse(1, 8'h80, 0, 0, 0);
    exp7 = 0;
    chk("R2", status_o[7], exp7);
    chk("R2", busy_o, 0);
    pulse(1, 8'h7f, 0, 0, 0);
    exp7 = 1;
    chk("R2", status_o[7], exp7);
    chk("R10", status_o[5:0], 0);
    for (int i = 0; i < 5; i++) begin
      chk("R2", busy_o | erase_done_o, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_read_toggle;
    for (int i = 0; i < 3; i++) begin
      status_rd_i = 1;
      chk("R4", status_o[6], exp6);
      @(negedge clk);
      exp6 = ~exp6;
      chk("R4", status_o[6], exp6);
    end
    status_rd_i = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R4", status_o[6], exp6);
  endtask

  task automatic t_sector;
    pulse(0, 8'h00, 0, 1, 0);
    exp7 = 0;
    chk("R3", status_o[7], 0);
    chk("R3", busy_o, 1);
    chk("R10", status_o[5:0], 0);
    run_erase("R5", SEC);
  endtask

  task automatic t_chip;
    pulse(0, 8'h00, 1, 0, 0);
    exp7 = 0;
    chk("R3", status_o[7], 0);
    run_erase("R6", CHIP);
  endtask

  task automatic t_reload;
    int done_seen = 0;
    pulse(0, 8'h00, 0, 1, 0);
    exp7 = 0;
    for (int i = 0; i < SEC - 2; i++) begin
      done_seen += erase_done_o;
      @(negedge clk);
    end
    pulse(0, 8'h00, 0, 1, 0);
    chk("R8", done_seen, 0);
    run_erase("R8", SEC);
  endtask

  task automatic t_priority;
    pulse(0, 8'h00, 1, 1, 0);
    exp7 = 0;
    run_erase("R9", CHIP);
    pulse(1, 8'h00, 0, 1, 0);
    exp7 = 0;
    chk("R9", status_o[7], 0);
    run_erase("R9", SEC);
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_program();
    t_read_toggle();
    t_sector();
    t_chip();
    t_reload();
    t_priority();
    t_read_toggle();
    report();
  end
endmodule